// File: doc/BRIEF.md
# Silence-Delimited Serial Frame Receiver

This block sits behind a UART receiver that has already turned line bits into bytes. It splits the incoming byte stream into message frames purely by measuring line silence: a frame closes once the line has been quiet for at least three and a half character times. No byte value marks a boundary. The silence is counted in baud ticks, and the length of one character in ticks is a run-time input, so the threshold follows the configured line rate. A character on this kind of line is eleven bit times long.

A frame is an address byte, a function byte, any number of data bytes, and a 16-bit check word sent low byte first. The block compares the address byte with the local station address and also accepts the broadcast address zero. For an addressed frame it passes every byte to a downstream buffer as it arrives. When the frame closes, it raises a one-cycle good or bad pulse. The buffer keeps the bytes on a good pulse and drops them on a bad pulse. The check word is computed one byte per strobe, a nibble at a time, from a 16-entry table.

Top module: `rtu_frame_rx`

## Requirements
- R1: After reset all outputs are low, and bytes are dropped with no output until the line has first been silent for the full threshold.
- R2: The silence threshold is ceil(3.5 × `char_ticks`) baud ticks, counted from the last byte strobe. A frame closes in the cycle after the count reaches the threshold, and the result pulse is visible one clock later.
- R3: A byte that arrives before the threshold is reached belongs to the current frame, so two frames run together are reported as one bad frame.
- R4: The first byte after silence is the address. The frame is addressed to this station if that byte equals `local_addr` or equals 0x00 (broadcast).
- R5: Every byte of an addressed frame appears on `out_byte` with `out_byte_valid` one clock after its strobe, in arrival order, including the address byte and both check bytes.
- R6: A frame whose address byte is neither `local_addr` nor 0x00 produces no byte output and no result pulse.
- R7: The check word uses the reflected polynomial 0xA001 with start value 0xFFFF, sent low byte first. `frame_ok` pulses for an addressed frame of at least 4 bytes whose running check over all bytes, the check bytes included, ends at zero.
- R8: `frame_err` pulses for an addressed frame whose check fails or which is shorter than 4 bytes.
- R9: If silence cuts a frame short, the partial frame is closed and reported as bad, and the next byte starts a new frame as its address. A byte that arrives in the same cycle as the close starts the next frame.
- R10: `frame_ok` and `frame_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| char_ticks | input | CHAR_W | Baud ticks per character |
| local_addr | input | 8 | Station address |
| rx_valid | input | 1 | Byte strobe from the UART |
| rx_data | input | 8 | Received byte |
| out_byte_valid | output | 1 | Forwarded byte strobe |
| out_byte | output | 8 | Forwarded byte |
| frame_ok | output | 1 | Frame accepted pulse |
| frame_err | output | 1 | Frame rejected pulse |

## Verification
A forwarded byte is due exactly one clock after its strobe. A result pulse is due two clocks after the tick that brings the silence count to the threshold. The bench generates its own baud ticks and counts them. It confirms that no pulse has appeared one tick short of the threshold, then checks for the pulse two edges after the final tick, sampling a moment after the falling edge. Other checks wait well past the threshold and compare counts and captured bytes. The byte spacing is set exactly at the threshold and one tick under it, which exercises both the close-and-start path and run-on frames.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
    localparam logic [15:0] CRC_POLY = 16'hA001;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam int          MIN_LEN  = 4;
    localparam int          LEN_W    = $clog2(MIN_LEN + 1);

    typedef enum logic [1:0] {ST_SKIP, ST_IDLE, ST_RECV} rx_state_e;

    typedef struct packed {
        rx_state_e        state;
        logic [LEN_W-1:0] len;
        logic             match;
        logic [15:0]      crc;
        logic             ob_v;
        logic [7:0]       ob;
        logic             ok;
        logic             err;
    } frame_st_t;

    // Check-word contribution of one nibble: four reflected shift steps.
    function automatic logic [15:0] nib_entry(input logic [3:0] n);
        logic [15:0] c;
        c = {12'h000, n};
        for (int i = 0; i < 4; i++)
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        return c;
    endfunction
endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] char_ticks,
    output logic              gap
);
    localparam int CNT_W = CHAR_W + 3;

    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // ceil(3.5 * char_ticks) = (7 * char_ticks + 1) / 2
    always_comb begin
        thr = ((CNT_W'(char_ticks) * CNT_W'(7)) + CNT_W'(1)) >> 1;
        cnt_d = cnt_q;
        if (rx_valid)
            cnt_d = '0;
        else if (baud_tick && (cnt_q < thr))
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign gap = (cnt_q >= thr);

    // A byte strobe always restarts the silence measurement.
    assert_gap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && char_ticks != '0) |=> !gap);
endmodule

// File: rtl/rtu_crc_nib.sv
module rtu_crc_nib (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    import rtu_pkg::*;

    logic [15:0] tab [16];
    logic [15:0] mid;

    for (genvar gi = 0; gi < 16; gi++) begin : g_tab
        assign tab[gi] = nib_entry(4'(gi));
    end

    // Low nibble first, as the bits arrive least significant first.
    always_comb begin
        mid     = (crc_in >> 4) ^ tab[crc_in[3:0] ^ data[3:0]];
        crc_out = (mid >> 4) ^ tab[mid[3:0] ^ data[7:4]];
    end
endmodule

// File: rtl/rtu_frame_rx.sv
module rtu_frame_rx #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [CHAR_W-1:0] char_ticks,
    input  logic [7:0]        local_addr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              out_byte_valid,
    output logic [7:0]        out_byte,
    output logic              frame_ok,
    output logic              frame_err
);
    import rtu_pkg::*;

    frame_st_t   st_d, st_q;
    logic        gap;
    logic        begin_frame;
    logic        addr_hit;
    logic [15:0] crc_seed, crc_nx;

    rtu_gap_timer #(.CHAR_W(CHAR_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rx_valid   (rx_valid),
        .char_ticks (char_ticks),
        .gap        (gap)
    );

    // A byte opens a frame when the line is known quiet.
    assign begin_frame = rx_valid && ((st_q.state == ST_IDLE) || gap);
    assign addr_hit    = (rx_data == local_addr) || (rx_data == 8'h00);
    assign crc_seed    = begin_frame ? CRC_INIT : st_q.crc;

    rtu_crc_nib u_crc (
        .crc_in  (crc_seed),
        .data    (rx_data),
        .crc_out (crc_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ob_v = 1'b0;
        st_d.ok   = 1'b0;
        st_d.err  = 1'b0;
        unique case (st_q.state)
            ST_SKIP: begin
                if (gap && !rx_valid) st_d.state = ST_IDLE;
            end
            ST_IDLE: ;
            ST_RECV: begin
                if (gap) begin
                    if (st_q.match) begin
                        if (st_q.len >= LEN_W'(MIN_LEN) && st_q.crc == 16'h0000)
                            st_d.ok = 1'b1;
                        else
                            st_d.err = 1'b1;
                    end
                    if (!rx_valid) st_d.state = ST_IDLE;
                end else if (rx_valid) begin
                    if (st_q.len < LEN_W'(MIN_LEN)) st_d.len = st_q.len + LEN_W'(1);
                    st_d.crc  = crc_nx;
                    st_d.ob_v = st_q.match;
                    st_d.ob   = rx_data;
                end
            end
            default: st_d.state = ST_SKIP;
        endcase
        if (begin_frame) begin
            st_d.state = ST_RECV;
            st_d.len   = LEN_W'(1);
            st_d.match = addr_hit;
            st_d.crc   = crc_nx;
            st_d.ob_v  = addr_hit;
            st_d.ob    = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_SKIP;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte_valid = st_q.ob_v;
    assign out_byte       = st_q.ob;
    assign frame_ok       = st_q.ok;
    assign frame_err      = st_q.err;

    assert_echo_next_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_byte_valid |-> ($past(rx_valid) && out_byte == $past(rx_data)));

    assert_close_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_err) |-> $past(gap));

    assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_ok, frame_err}));

    assert_result_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok || frame_err) |=> !(frame_ok || frame_err));
endmodule

// File: tb/rtu_frame_rx_tb.sv
module rtu_frame_rx_tb;
    localparam int CHAR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              baud_tick = 1'b0;
    logic [CHAR_W-1:0] char_ticks = 8'd4;
    logic [7:0]        local_addr = 8'h11;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              out_byte_valid;
    logic [7:0]        out_byte;
    logic              frame_ok;
    logic              frame_err;

    int checks = 0;
    int errors = 0;
    int thr = 14;

    logic [7:0] cap [0:255];
    int cap_n = 0, ok_n = 0, err_n = 0;
    logic [7:0] fb [0:31];
    int fl = 0;
    int tdiv = 0;

    always #2 clk = ~clk;

    rtu_frame_rx #(.CHAR_W(CHAR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .char_ticks(char_ticks),
        .local_addr(local_addr), .rx_valid(rx_valid), .rx_data(rx_data),
        .out_byte_valid(out_byte_valid), .out_byte(out_byte),
        .frame_ok(frame_ok), .frame_err(frame_err)
    );

    // One baud tick every fourth clock, changed on the falling edge.
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        baud_tick <= (tdiv == 0);
    end

    always @(negedge clk) begin
        if (out_byte_valid && cap_n < 256) begin
            cap[cap_n] = out_byte;
            cap_n++;
        end
        if (frame_ok)  ok_n++;
        if (frame_err) err_n++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bits(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {8'h00, fb[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic build(input logic [7:0] addr, input int ndata, input logic [7:0] seed,
                         input bit good);
        logic [15:0] c;
        fb[0] = addr;
        fb[1] = 8'h03;
        for (int i = 0; i < ndata; i++) fb[2 + i] = seed + 8'(i);
        c = crc_bits(2 + ndata);
        if (!good) c ^= 16'h0100;
        fb[2 + ndata] = c[7:0];
        fb[3 + ndata] = c[15:8];
        fl = 4 + ndata;
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!baud_tick);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Sends fb[0..n-1] with the given tick spacing; no wait after the last byte.
    task automatic send_frame(input int n, input int spacing);
        for (int i = 0; i < n; i++) begin
            send_byte(fb[i]);
            if (i != n - 1) wait_ticks(spacing);
        end
    endtask

    task automatic quiet();
        wait_ticks(thr + 6);
        @(negedge clk); #1;
    endtask

    task automatic check_bytes(input string req, input int base, input int n);
        for (int i = 0; i < n; i++)
            check(req, int'(cap[base + i]), int'(fb[i]));
    endtask

    task automatic t_reset();
        int c0;
        @(negedge clk); #1;
        check("R1 out_byte_valid in reset", int'(out_byte_valid), 0);
        check("R1 frame_ok in reset", int'(frame_ok), 0);
        check("R1 frame_err in reset", int'(frame_err), 0);
        rst_n = 1'b1;
        c0 = cap_n;
        build(8'h11, 2, 8'h40, 1'b1);
        send_frame(fl, 2);
        quiet();
        check("R1 no bytes before first silence", cap_n - c0, 0);
        check("R1 no ok before first silence", ok_n, 0);
        check("R1 no err before first silence", err_n, 0);
    endtask

    task automatic t_good_timing();
        int c0 = cap_n, o0 = ok_n, e0 = err_n;
        build(8'h11, 5, 8'h00, 1'b1);
        send_frame(fl, 2);
        wait_ticks(thr - 1);
        @(negedge clk); #1;
        check("R2 no close one tick early", ok_n - o0, 0);
        wait_ticks(1);
        @(negedge clk);
        @(negedge clk); #1;
        check("R2 close two edges after threshold", ok_n - o0, 1);
        check("R7 good frame no err", err_n - e0, 0);
        check("R5 byte count", cap_n - c0, fl);
        check_bytes("R5 byte value", c0, fl);
        quiet();
    endtask

    task automatic t_broadcast();
        int c0 = cap_n, o0 = ok_n;
        build(8'h00, 1, 8'h77, 1'b1);
        send_frame(fl, 3);
        quiet();
        check("R4 broadcast accepted", ok_n - o0, 1);
        check("R4 broadcast bytes", cap_n - c0, fl);
        check_bytes("R4 broadcast value", c0, fl);
    endtask

    task automatic t_foreign();
        int c0 = cap_n, o0 = ok_n, e0 = err_n;
        build(8'h22, 3, 8'h10, 1'b1);
        send_frame(fl, 2);
        quiet();
        build(8'h23, 0, 8'h00, 1'b0);
        send_frame(fl, 2);
        quiet();
        check("R6 foreign bytes", cap_n - c0, 0);
        check("R6 foreign ok", ok_n - o0, 0);
        check("R6 foreign err", err_n - e0, 0);
    endtask

    task automatic t_bad_crc();
        int o0 = ok_n, e0 = err_n;
        build(8'h11, 4, 8'hA0, 1'b0);
        send_frame(fl, 2);
        quiet();
        check("R8 bad check word err", err_n - e0, 1);
        check("R8 bad check word ok", ok_n - o0, 0);
    endtask

    task automatic t_short();
        int o0 = ok_n, e0 = err_n;
        fb[0] = 8'h11; fb[1] = 8'h03; fb[2] = 8'h00;
        send_frame(3, 2);
        quiet();
        check("R8 short frame err", err_n - e0, 1);
        check("R8 short frame ok", ok_n - o0, 0);
    endtask

    task automatic t_runon();
        int o0 = ok_n, e0 = err_n, c0 = cap_n;
        build(8'h11, 2, 8'h05, 1'b1);
        send_frame(fl, thr - 1);
        wait_ticks(thr - 1);
        send_frame(fl, thr - 1);
        quiet();
        check("R3 run-on single err", err_n - e0, 1);
        check("R3 run-on no ok", ok_n - o0, 0);
        check("R3 run-on bytes", cap_n - c0, 2 * fl);
    endtask

    task automatic t_spacing_under();
        int o0 = ok_n;
        build(8'h11, 3, 8'h31, 1'b1);
        send_frame(fl, thr - 1);
        quiet();
        check("R3 spacing one tick under continues", ok_n - o0, 1);
    endtask

    task automatic t_exact_gap();
        int o0 = ok_n, e0 = err_n;
        build(8'h11, 2, 8'h90, 1'b1);
        send_frame(fl, 2);
        wait_ticks(thr);
        send_frame(fl, 2);
        quiet();
        check("R9 close and start same cycle ok", ok_n - o0, 2);
        check("R9 close and start same cycle err", err_n - e0, 0);
    endtask

    task automatic t_partial();
        int o0 = ok_n, e0 = err_n;
        build(8'h11, 3, 8'h60, 1'b1);
        send_frame(3, 2);
        wait_ticks(thr + 2);
        send_frame(fl, 2);
        quiet();
        check("R9 partial flushed as err", err_n - e0, 1);
        check("R9 next frame accepted", ok_n - o0, 1);
    endtask

    task automatic t_char_ticks();
        int o0 = ok_n, e0 = err_n;
        char_ticks = 8'd2;
        thr = 7;
        quiet();
        build(8'h11, 1, 8'h21, 1'b1);
        send_frame(fl, 6);
        wait_ticks(7);
        send_frame(fl, 2);
        quiet();
        check("R2 shorter character two frames", ok_n - o0, 2);
        check("R2 shorter character no err", err_n - e0, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_good_timing();
        t_broadcast();
        t_foreign();
        t_bad_crc();
        t_short();
        t_runon();
        t_spacing_under();
        t_exact_gap();
        t_partial();
        t_char_ticks();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule